// File: doc/BRIEF.md
# Framed Video Test Pattern Injector

This block sits in one data lane of an image sensor's output path, one word slot per clock. Each cycle it receives a pixel word, and it can also receive frame-start, frame-end, line-start and line-end markers. It emits one word per cycle. That word is either the pixel word, a synthesized test word, a training word, or a CRC word. A CRC word follows each line.

Four modes are available: normal pass-through, a fixed constant, an incrementing count and a pseudo-random sequence. A framed flag decides how test data relates to the active window. When the flag is set, test data appears only inside the frame and line windows, and training words fill the gaps. When the flag is clear, test data fills every slot. One shared pattern/seed input supplies the constant, the start count or the generator seed, depending on the mode.

Top module: `tpInject`

## Requirements
- R1: With `prbsEn`=0 and `patEn`=0 (normal mode), a word inside the active window is output unchanged with `validOut`=1. The active window runs from the line-start word to the line-end word inclusive, and it must also lie inside a frame, which runs from the frame-start word to the frame-end word. `framedMode` has no effect in normal mode.
- R2: With `prbsEn`=0, `patEn`=1 and `incSel`=0, every emitted word equals `patSeed`.
- R3: With `prbsEn`=0, `patEn`=1 and `incSel`=1, the first emitted word of a frame equals `patSeed`. Each later emitted word is one greater than the one before, wrapping from 0x3FF to 0x000. The count continues across line boundaries and is reloaded only at frame start.
- R4: With `prbsEn`=1 the generator runs, whatever `patEn` and `incSel` are set to. On the first cycle in this mode the state is loaded from `patSeed`, or from 1 if the seed is zero, and that state is the first emitted word. Each later emitted word is the previous word shifted left by one bit, with bit 9 XOR bit 6 shifted into bit 0.
- R5: In normal mode, and in any test mode with `framedMode`=1, each slot outside the active window carries the training word 0x3A6 with `validOut`=0. The only exception is the CRC slot.
- R6: In a test mode with `framedMode`=0, every slot carries test data with `validOut`=1. No training word and no CRC word appears.
- R7: In normal, fixed and incrementing modes, the slot after a line-end word carries a CRC with `crcOut`=1 and `validOut`=0, appearing on the output two cycles after that line-end input. The CRC uses the polynomial x^10+x^9+x^6+x^3+x^2+1 (0x24D). It is preset to 0x3FF at line start and covers every emitted word of the line, each word processed MSB first.
- R8: In PRBS mode no CRC is emitted. The slot after a line end carries the training word with `crcOut`=0.
- R9: Outputs are registered with one cycle of latency. The four marker outputs repeat the input markers, aligned with the word they came with.
- R10: During reset, `dataOut` is 0x3A6 and `validOut`, `crcOut` and all marker outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixIn | input | 10 | Pixel word of this slot |
| frameStart | input | 1 | Slot is the first word of a frame |
| frameEnd | input | 1 | Slot is the last word of a frame |
| lineStart | input | 1 | Slot is the first word of a line |
| lineEnd | input | 1 | Slot is the last word of a line |
| prbsEn | input | 1 | Select pseudo-random generator (overrides the others) |
| patEn | input | 1 | Select a test pattern |
| incSel | input | 1 | With patEn: 0 fixed, 1 incrementing |
| framedMode | input | 1 | Test data obeys the windows |
| patSeed | input | 10 | Constant, start count or generator seed |
| dataOut | output | 10 | Output word |
| validOut | output | 1 | dataOut is a pixel or test word |
| crcOut | output | 1 | dataOut is the line CRC |
| frameStartOut | output | 1 | Delayed frameStart |
| frameEndOut | output | 1 | Delayed frameEnd |
| lineStartOut | output | 1 | Delayed lineStart |
| lineEndOut | output | 1 | Delayed lineEnd |

## Verification
The assertions check several properties on every cycle:
- a CRC slot only ever follows a line-end word, and never follows a PRBS cycle;
- a CRC slot is never also a valid word;
- an idle slot always carries the training word;
- a fixed-mode word always equals the seed of the previous cycle;
- a PRBS word is never zero.

Only the bench scenarios can show the rest, because these need word sequences and reference values:
- the counter wrap and the reload at frame start;
- the generator sequence, its zero-seed substitution and its reload when the mode is entered;
- the CRC values;
- the unframed behaviour.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_INC    = 2'd2,
    MODE_PRBS   = 2'd3
  } tpMode_e;

  // Strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic useTest;     // replace pixel word by generated word
    logic emit;        // slot carries a valid word
    logic crcSlot;     // slot carries the line CRC
    logic crcSeed;     // preset CRC before this word
    logic crcUpdate;   // fold this word into the CRC
    logic advance;     // step the active generator after this word
    logic reloadInc;   // load counter from seed
    logic reloadPrbs;  // load LFSR from seed
  } tpStrobe_t;

endpackage

// File: rtl/tpCtrl.sv
module tpCtrl
  import tp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      prbsEn,
  input  logic      patEn,
  input  logic      incSel,
  input  logic      framedMode,
  input  logic      frameStart,
  input  logic      frameEnd,
  input  logic      lineStart,
  input  logic      lineEnd,
  output tpMode_e   mode,
  output tpStrobe_t stb
);

  tpMode_e modePrev;
  logic inFrame, inLine, crcPending;
  logic windowed, winNow, noCrcMode;

  // Mode decode: generator has priority over the pattern controls
  always_comb begin
    if (prbsEn)      mode = MODE_PRBS;
    else if (patEn)  mode = incSel ? MODE_INC : MODE_FIXED;
    else             mode = MODE_NORMAL;
  end

  assign windowed  = (mode == MODE_NORMAL) || framedMode;
  assign winNow    = (frameStart || inFrame) && (lineStart || inLine);
  assign noCrcMode = (mode == MODE_PRBS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame    <= 1'b0;
      inLine     <= 1'b0;
      crcPending <= 1'b0;
      modePrev   <= MODE_NORMAL;
    end else begin
      inFrame    <= frameEnd ? 1'b0 : (frameStart ? 1'b1 : inFrame);
      inLine     <= lineEnd  ? 1'b0 : (lineStart  ? 1'b1 : inLine);
      crcPending <= lineEnd && winNow && windowed && !noCrcMode;
      modePrev   <= mode;
    end
  end

  always_comb begin
    stb            = '0;
    stb.useTest    = (mode != MODE_NORMAL);
    stb.emit       = windowed ? winNow : 1'b1;
    stb.crcSlot    = crcPending && windowed && !noCrcMode;
    stb.crcSeed    = lineStart;
    stb.crcUpdate  = windowed && winNow && !noCrcMode;
    stb.advance    = stb.emit && stb.useTest;
    stb.reloadInc  = frameStart;
    stb.reloadPrbs = noCrcMode && (modePrev != MODE_PRBS);
  end

  // CRC slot only directly after a line-end word
  assert_crc_after_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.crcSlot |-> $past(lineEnd));

  // no CRC slot following a PRBS-mode cycle
  assert_no_crc_prbs_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.crcSlot |-> ($past(mode) != MODE_PRBS));

endmodule

// File: rtl/tpDatapath.sv
module tpDatapath
  import tp_pkg::*;
#(
  parameter int              W         = 10,
  parameter logic [W-1:0]    TRAIN     = 10'h3A6,
  parameter logic [W-1:0]    LFSR_TAPS = 10'h240,
  parameter logic [W-1:0]    CRC_POLY  = 10'h24D
) (
  input  logic         clk,
  input  logic         rstN,
  input  tpMode_e      mode,
  input  tpStrobe_t    stb,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] pixIn,
  input  logic         frameStart,
  input  logic         frameEnd,
  input  logic         lineStart,
  input  logic         lineEnd,
  output logic [W-1:0] dataOut,
  output logic         validOut,
  output logic         crcOut,
  output logic         frameStartOut,
  output logic         frameEndOut,
  output logic         lineStartOut,
  output logic         lineEndOut
);

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  function automatic logic [W-1:0] crcStep(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    logic fb;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] lfsrStep(input logic [W-1:0] x);
    return {x[W-2:0], ^(x & LFSR_TAPS)};
  endfunction

  logic [W-1:0] incReg, incCur, lfsrReg, prbsCur, seedNz;
  logic [W-1:0] crcReg, crcCur, testWord, word;

  assign seedNz  = (seed == '0) ? ONE : seed;
  assign incCur  = stb.reloadInc  ? seed   : incReg;
  assign prbsCur = stb.reloadPrbs ? seedNz : lfsrReg;
  assign crcCur  = stb.crcSeed    ? ALL_ONES : crcReg;

  always_comb begin
    unique case (mode)
      MODE_FIXED: testWord = seed;
      MODE_INC:   testWord = incCur;
      MODE_PRBS:  testWord = prbsCur;
      default:    testWord = seed;
    endcase
  end

  assign word = stb.useTest ? testWord : pixIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      incReg        <= '0;
      lfsrReg       <= ONE;
      crcReg        <= ALL_ONES;
      dataOut       <= TRAIN;
      validOut      <= 1'b0;
      crcOut        <= 1'b0;
      frameStartOut <= 1'b0;
      frameEndOut   <= 1'b0;
      lineStartOut  <= 1'b0;
      lineEndOut    <= 1'b0;
    end else begin
      incReg  <= (stb.advance && mode == MODE_INC)  ? incCur + ONE      : incCur;
      lfsrReg <= (stb.advance && mode == MODE_PRBS) ? lfsrStep(prbsCur) : prbsCur;
      crcReg  <= stb.crcUpdate ? crcStep(crcCur, word) : crcCur;
      if (stb.crcSlot) begin
        dataOut  <= crcReg;
        validOut <= 1'b0;
        crcOut   <= 1'b1;
      end else begin
        dataOut  <= stb.emit ? word : TRAIN;
        validOut <= stb.emit;
        crcOut   <= 1'b0;
      end
      frameStartOut <= frameStart;
      frameEndOut   <= frameEnd;
      lineStartOut  <= lineStart;
      lineEndOut    <= lineEnd;
    end
  end

  assert_crc_not_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(crcOut && validOut));

  assert_fixed_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(mode) == MODE_FIXED) |-> (dataOut == $past(seed)));

  assert_prbs_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(mode) == MODE_PRBS) |-> (dataOut != '0));

  assert_idle_training_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!validOut && !crcOut) |-> (dataOut == TRAIN));

endmodule

// File: rtl/tpInject.sv
module tpInject
  import tp_pkg::*;
#(
  parameter int           W     = 10,
  parameter logic [W-1:0] TRAIN = 10'h3A6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pixIn,
  input  logic         frameStart,
  input  logic         frameEnd,
  input  logic         lineStart,
  input  logic         lineEnd,
  input  logic         prbsEn,
  input  logic         patEn,
  input  logic         incSel,
  input  logic         framedMode,
  input  logic [W-1:0] patSeed,
  output logic [W-1:0] dataOut,
  output logic         validOut,
  output logic         crcOut,
  output logic         frameStartOut,
  output logic         frameEndOut,
  output logic         lineStartOut,
  output logic         lineEndOut
);

  tpMode_e   mode;
  tpStrobe_t stb;

  tpCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .prbsEn(prbsEn), .patEn(patEn), .incSel(incSel), .framedMode(framedMode),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .lineStart(lineStart), .lineEnd(lineEnd),
    .mode(mode), .stb(stb)
  );

  tpDatapath #(.W(W), .TRAIN(TRAIN)) uData (
    .clk(clk), .rstN(rstN), .mode(mode), .stb(stb),
    .seed(patSeed), .pixIn(pixIn),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .lineStart(lineStart), .lineEnd(lineEnd),
    .dataOut(dataOut), .validOut(validOut), .crcOut(crcOut),
    .frameStartOut(frameStartOut), .frameEndOut(frameEndOut),
    .lineStartOut(lineStartOut), .lineEndOut(lineEndOut)
  );

endmodule

// File: tb/tb_tpInject.sv
module tb_tpInject;

  localparam logic [9:0] TRAIN = 10'h3A6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] pixIn = '0, patSeed = '0;
  logic frameStart = 0, frameEnd = 0, lineStart = 0, lineEnd = 0;
  logic prbsEn = 0, patEn = 0, incSel = 0, framedMode = 1;
  logic [9:0] dataOut;
  logic validOut, crcOut, frameStartOut, frameEndOut, lineStartOut, lineEndOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tpInject dut (
    .clk(clk), .rstN(rstN), .pixIn(pixIn),
    .frameStart(frameStart), .frameEnd(frameEnd), .lineStart(lineStart), .lineEnd(lineEnd),
    .prbsEn(prbsEn), .patEn(patEn), .incSel(incSel), .framedMode(framedMode),
    .patSeed(patSeed), .dataOut(dataOut), .validOut(validOut), .crcOut(crcOut),
    .frameStartOut(frameStartOut), .frameEndOut(frameEndOut),
    .lineStartOut(lineStartOut), .lineEndOut(lineEndOut)
  );

  function automatic logic [9:0] crcRef(input logic [9:0] c, input logic [9:0] d);
    logic [9:0] r = c;
    for (int i = 9; i >= 0; i--) begin
      logic fb = r[9] ^ d[i];
      r = {r[8:0], 1'b0} ^ (fb ? 10'h24D : 10'h000);
    end
    return r;
  endfunction

  function automatic logic [9:0] lfsrRef(input logic [9:0] x);
    return {x[8:0], x[9] ^ x[6]};
  endfunction

  task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // drive a slot at the falling edge, return just after the capturing edge
  task automatic cyc(input logic fs, input logic fe, input logic ls, input logic le,
                     input logic [9:0] pix);
    @(negedge clk);
    frameStart = fs; frameEnd = fe; lineStart = ls; lineEnd = le; pixIn = pix;
    @(posedge clk);
    #2;
  endtask

  task automatic cfg(input logic p, input logic t, input logic inc, input logic fr,
                     input logic [9:0] s);
    prbsEn = p; patEn = t; incSel = inc; framedMode = fr; patSeed = s;
  endtask

  // table: prbs, pat, inc, framed, seed, pix, expected word
  typedef struct packed {
    logic p; logic t; logic inc; logic fr;
    logic [9:0] seed; logic [9:0] pix; logic [9:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 10'h155, 10'h155},
    '{1'b0, 1'b0, 1'b0, 1'b0, 10'h0F0, 10'h2AA, 10'h2AA},
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'h0F0, 10'h123, 10'h0F0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 10'h3FF, 10'h123, 10'h3FF},
    '{1'b1, 1'b1, 1'b1, 1'b1, 10'h005, 10'h123, 10'h005},
    '{1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 10'h000, 10'h000},
    '{1'b1, 1'b0, 1'b0, 1'b1, 10'h000, 10'h321, 10'h001},
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'h3A6, 10'h001, 10'h3A6}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    logic [9:0] crc, exp;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 data", dataOut, TRAIN);
    chk("R10 valid", {9'd0, validOut}, 10'd0);
    chk("R10 crc", {9'd0, crcOut}, 10'd0);
    chk("R10 markers", {6'd0, frameStartOut, frameEndOut, lineStartOut, lineEndOut}, 10'd0);
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 10'h0);

    // table walk: one-word frames, then CRC slot, then idle slot
    foreach (VECS[i]) begin
      cfg(VECS[i].p, VECS[i].t, VECS[i].inc, VECS[i].fr, VECS[i].seed);
      cyc(1, 1, 1, 1, VECS[i].pix);
      chk("R1/R2/R3/R4 table word", dataOut, VECS[i].exp);
      chk("R9 valid+markers", {5'd0, validOut, frameStartOut, frameEndOut, lineStartOut, lineEndOut},
          10'h01F);
      cyc(0, 0, 0, 0, 10'h0);
      if (VECS[i].p) begin
        chk("R8 no crc in prbs", dataOut, TRAIN);
        chk("R8 crc flag", {9'd0, crcOut}, 10'd0);
      end else begin
        chk("R7 crc value", dataOut, crcRef(10'h3FF, VECS[i].exp));
        chk("R7 crc flag/valid", {8'd0, crcOut, validOut}, 10'b10);
      end
      cyc(0, 0, 0, 0, 10'h2F0);
      chk("R5 idle training", dataOut, TRAIN);
    end

    // R3 incrementing wrap, continuation across lines, CRC over a line
    cfg(0, 1, 1, 1, 10'h3FE);
    crc = 10'h3FF;
    exp = 10'h3FE;
    for (int k = 0; k < 4; k++) begin
      cyc(k == 0, 0, k == 0, k == 3, 10'h0);
      chk("R3 inc word", dataOut, exp);
      crc = crcRef(crc, exp);
      exp = exp + 10'd1;
    end
    chk("R9 lineEndOut", {9'd0, lineEndOut}, 10'd1);
    cyc(0, 0, 0, 0, 10'h0);
    chk("R7 crc line1", dataOut, crc);
    cyc(0, 0, 0, 0, 10'h111);
    chk("R5 gap training", dataOut, TRAIN);
    chk("R5 gap valid", {9'd0, validOut}, 10'd0);
    crc = 10'h3FF;
    for (int k = 0; k < 2; k++) begin
      cyc(0, k == 1, k == 0, k == 1, 10'h0);
      chk("R3 inc line2", dataOut, exp);
      crc = crcRef(crc, exp);
      exp = exp + 10'd1;
    end
    cyc(0, 0, 0, 0, 10'h0);
    chk("R7 crc line2", dataOut, crc);

    // R4 PRBS sequence after entering the mode, R8 no CRC
    cfg(0, 0, 0, 1, 10'h0);
    cyc(0, 0, 0, 0, 10'h0);
    cfg(1, 0, 0, 1, 10'h001);
    exp = 10'h001;
    for (int k = 0; k < 5; k++) begin
      cyc(k == 0, k == 4, k == 0, k == 4, 10'h0);
      chk("R4 prbs word", dataOut, exp);
      exp = lfsrRef(exp);
    end
    cyc(0, 0, 0, 0, 10'h0);
    chk("R8 slot training", dataOut, TRAIN);
    chk("R8 slot flag", {9'd0, crcOut}, 10'd0);

    // R6 unframed fixed: always valid test data, no CRC after line end
    cfg(0, 1, 0, 0, 10'h2C1);
    cyc(0, 0, 0, 0, 10'h0AA);
    chk("R6 unframed word", dataOut, 10'h2C1);
    cyc(0, 0, 0, 1, 10'h0AA);
    chk("R6 unframed valid", {9'd0, validOut}, 10'd1);
    cyc(0, 0, 0, 0, 10'h0AA);
    chk("R6 no crc slot", {8'd0, crcOut, validOut}, 10'b01);
    chk("R6 slot data", dataOut, 10'h2C1);

    // R6 unframed incrementing
    cfg(0, 1, 1, 0, 10'h010);
    for (int k = 0; k < 3; k++) begin
      cyc(k == 0, 0, 0, 0, 10'h0);
      chk("R6 unframed inc", dataOut, 10'h010 + 10'(k));
    end

    // R1/R5 normal mode ignores framedMode: outside window gives training
    cfg(0, 0, 0, 0, 10'h0);
    cyc(0, 0, 0, 0, 10'h155);
    chk("R5 normal outside", dataOut, TRAIN);
    chk("R1 normal outside valid", {9'd0, validOut}, 10'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule